// File: doc/BRIEF.md
# Synchronous Serial Port with FIFOs

This block is a register-mapped serial port for a simple word-wide host bus. The host writes outgoing words into a transmit queue. It reads incoming words from a receive queue. Status and control live in a small set of word registers. On the serial side the block acts as the clock master. It drives a bit clock and a data line, and it samples a return data line. Clock polarity and clock phase follow the four usual SPI modes. Word length can be set from 4 to 16 bits, and the bit rate comes from a programmable divider of the port clock.

Both queues raise level-based service requests at programmable levels, and each request can be enabled as an interrupt. A receive word that finds the queue full is dropped, and a sticky flag records the loss. An idle timer flags a receive queue that holds data but has seen no traffic for a programmed number of clocks. An internal loopback routes the outgoing data straight into the receiver. Chip select is not part of the block, because software drives it as a general-purpose pin.

Top module: `ssp_port`

## Requirements
- R1: After reset, `sclk`, `txd` and `irq` are 0 and the status register (offset 0x08) reads 0x24: bit 2 (transmit queue not full) and bit 5 (transmit service request) are set, and all other bits are clear.
- R2: Control A (0x00), control B (0x04) and the idle limit (0x28) read back what was written, masked to their implemented bits: 0x000FFFBF for control A, 0x00083FDF for control B, and the low 16 bits for the idle limit.
- R3: A write to offset 0x10 while control A bit 7 (enable) is set queues a word. The word is sent most significant bit first with a length of control A[3:0]+1 bits (4 to 16). A read of 0x10 pops the received word, right-justified and zero-extended. With control B bit 2 (loopback) set, the received word equals the sent word.
- R4: With loopback clear, the receiver samples the `rxd` input instead of the transmit line.
- R5: `sclk` rests at control B bit 3 (polarity) while no frame is shifting. During a frame it leaves the rest level once per bit, and each half period lasts control A[19:8]+1 port clocks.
- R6: With control B bit 4 (phase) clear, each data bit is valid at the clock edge that leaves the rest level. With phase set, each data bit is valid at the edge that returns to the rest level.
- R7: Status bit 5 is set while the transmit occupancy is at most control B[9:6]+1. When control B bit 1 is set, this request drives `irq`.
- R8: Status bit 6 is set while the receive occupancy is at least control B[13:10]+1. When control B bit 0 is set, this request drives `irq`.
- R9: A received word that arrives while the 16-entry receive queue is full is discarded and sets status bit 7. The bit stays set through reads and clears only when the host writes 1 to status bit 7.
- R10: With a non-zero idle limit, status bit 19 is set after the receive queue has been non-empty with no push or pop for that many clocks. When control B bit 19 is set, this flag drives `irq`. Writing 1 to status bit 19 clears it, and an idle limit of 0 disables the timer.
- R11: Clearing the enable bit empties both queues and stops the shifter, so status bits 3 and 4 read 0 and nothing is sent after the port is enabled again.
- R12: Status bit 4 (busy) is set while a frame is shifting or, with the port enabled, the transmit queue holds data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is valid after the next edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sclk | output | 1 | Serial bit clock |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach from the ports is a full receive queue with a seventeenth word still arriving. To get there, the host must keep feeding the transmitter while it holds back every receive read. The stimulus sets the fastest divisor with loopback on and queues seventeen short words. It reads nothing until the shifter goes idle, then drains the sixteen kept words and compares them with the first sixteen that were sent. Random frames sweep all four clock modes, word lengths and divisors. Each frame is checked against a bench model that decodes `sclk` and `txd` as an external receiver would.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int BUS_W   = 32;
  localparam int FRAME_W = 16;

  // register byte offsets
  localparam int OFS_CTLA = 'h00;
  localparam int OFS_CTLB = 'h04;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_DATA = 'h10;
  localparam int OFS_TOUT = 'h28;

  // control B bit positions
  localparam int CB_RIE  = 0;
  localparam int CB_TIE  = 1;
  localparam int CB_LOOP = 2;
  localparam int CB_CPOL = 3;
  localparam int CB_CPHA = 4;
  localparam int CB_TOIE = 19;

  // status bit positions
  localparam int ST_TNF = 2;
  localparam int ST_RNE = 3;
  localparam int ST_BSY = 4;
  localparam int ST_TSR = 5;
  localparam int ST_RSR = 6;
  localparam int ST_ROR = 7;
  localparam int ST_RTO = 19;

  typedef struct packed {
    logic        cpol;
    logic        cpha;
    logic        loop;
    logic [3:0]  size_m1;
    logic [11:0] div_m1;
  } line_cfg_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import ssp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  line_cfg_t          cfg,
  input  logic               tx_ready,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               tx_take,
  input  logic               rxd,
  output logic               rx_push,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sclk,
  output logic               txd,
  output logic               active
);
  logic [4:0]         n_bits;
  logic [5:0]         last_half, half;
  logic [11:0]        tick;
  logic [FRAME_W-1:0] sreg, rxs, load_word, mask, cap;
  logic               sclk_q, txd_q, in_bit, edge_now, leading;

  assign n_bits    = (cfg.size_m1 < 4'd3) ? 5'd4 : {1'b0, cfg.size_m1} + 5'd1;
  assign last_half = {n_bits, 1'b0} - 6'd1;
  assign load_word = tx_word << (5'd16 - n_bits);
  assign mask      = 16'hFFFF >> (5'd16 - n_bits);
  assign in_bit    = cfg.loop ? txd_q : rxd;
  assign edge_now  = active && (tick == cfg.div_m1);
  assign leading   = !half[0];
  assign tx_take   = en && !active && tx_ready;
  assign rx_push   = edge_now && (half == last_half);
  assign cap       = cfg.cpha ? {rxs[FRAME_W-2:0], in_bit} : rxs;
  assign rx_word   = cap & mask;
  assign sclk      = sclk_q ^ cfg.cpol;
  assign txd       = txd_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active <= 1'b0;
      half   <= '0;
      tick   <= '0;
      sreg   <= '0;
      rxs    <= '0;
      sclk_q <= 1'b0;
      txd_q  <= 1'b0;
    end else if (!active) begin
      if (tx_ready) begin
        active <= 1'b1;
        half   <= '0;
        tick   <= '0;
        rxs    <= '0;
        if (!cfg.cpha) begin
          txd_q <= load_word[FRAME_W-1];
          sreg  <= load_word << 1;
        end else begin
          sreg  <= load_word;
        end
      end
    end else if (edge_now) begin
      tick   <= '0;
      sclk_q <= !sclk_q;
      if (leading) begin
        if (cfg.cpha) begin
          txd_q <= sreg[FRAME_W-1];
          sreg  <= sreg << 1;
        end else begin
          rxs <= {rxs[FRAME_W-2:0], in_bit};
        end
      end else begin
        if (cfg.cpha) begin
          rxs <= {rxs[FRAME_W-2:0], in_bit};
        end else if (half != last_half) begin
          txd_q <= sreg[FRAME_W-1];
          sreg  <= sreg << 1;
        end
      end
      if (half == last_half) active <= 1'b0;
      else                   half   <= half + 6'd1;
    end else begin
      tick <= tick + 12'd1;
    end
  end
endmodule

// File: rtl/ssp_idle_timer.sv
module ssp_idle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] limit,
  input  logic         watch,
  input  logic         activity,
  output logic         fire
);
  logic [W-1:0] cnt;

  assign fire = watch && !activity && (limit != '0) && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || limit == '0 || !watch || activity) cnt <= '0;
    else if (cnt != limit)                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int TO_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              sclk,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(OFS_CTLA);
  localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(OFS_CTLB);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_TOUT = ADDR_W'(OFS_TOUT);

  logic [3:0]  size_m1_q;
  logic [1:0]  fmt_q;
  logic        en;
  logic [11:0] div_q;
  logic        rie_q, tie_q, loop_q, cpol, cpha_q, toie_q;
  logic [3:0]  txthr_q, rxthr_q;
  logic [TO_W-1:0] to_lim;
  logic        ovr_q, tof_q;

  logic sel_ctla, sel_ctlb, sel_stat, sel_data, sel_tout;
  logic stat_wr, tx_push, rx_pop, tx_take, rx_push, active, busy;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_svc, rx_svc, to_fire;
  logic [CW-1:0]      tx_cnt, rx_cnt;
  logic [FRAME_W-1:0] tx_dout, rx_dout, rx_word;
  logic [BUS_W-1:0]   stat, ctla_rd, ctlb_rd;
  line_cfg_t          cfg;
  logic               unused_bits;

  assign unused_bits = ^wdata[BUS_W-1:20];

  assign sel_ctla = (addr == A_CTLA);
  assign sel_ctlb = (addr == A_CTLB);
  assign sel_stat = (addr == A_STAT);
  assign sel_data = (addr == A_DATA);
  assign sel_tout = (addr == A_TOUT);
  assign stat_wr  = wr_en && sel_stat;
  assign tx_push  = wr_en && sel_data && en;
  assign rx_pop   = rd_en && sel_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      size_m1_q <= '0; fmt_q <= '0; en <= 1'b0; div_q <= '0;
      rie_q <= 1'b0; tie_q <= 1'b0; loop_q <= 1'b0;
      cpol <= 1'b0; cpha_q <= 1'b0; toie_q <= 1'b0;
      txthr_q <= '0; rxthr_q <= '0; to_lim <= '0;
    end else if (wr_en) begin
      if (sel_ctla) begin
        size_m1_q <= wdata[3:0];
        fmt_q     <= wdata[5:4];
        en        <= wdata[7];
        div_q     <= wdata[19:8];
      end
      if (sel_ctlb) begin
        rie_q   <= wdata[CB_RIE];
        tie_q   <= wdata[CB_TIE];
        loop_q  <= wdata[CB_LOOP];
        cpol    <= wdata[CB_CPOL];
        cpha_q  <= wdata[CB_CPHA];
        txthr_q <= wdata[9:6];
        rxthr_q <= wdata[13:10];
        toie_q  <= wdata[CB_TOIE];
      end
      if (sel_tout) to_lim <= wdata[TO_W-1:0];
    end
  end

  assign cfg = '{cpol: cpol, cpha: cpha_q, loop: loop_q,
                 size_m1: size_m1_q, div_m1: div_q};

  ssp_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(!en), .push(tx_push), .din(wdata[FRAME_W-1:0]),
    .pop(tx_take), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  ssp_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(!en), .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  ssp_shifter u_shift (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg), .tx_ready(!tx_empty),
    .tx_word(tx_dout), .tx_take(tx_take), .rxd(rxd), .rx_push(rx_push),
    .rx_word(rx_word), .sclk(sclk), .txd(txd), .active(active)
  );

  ssp_idle_timer #(.W(TO_W)) u_idle (
    .clk(clk), .rst(rst), .limit(to_lim), .watch(!rx_empty),
    .activity(rx_push || rx_pop), .fire(to_fire)
  );

  assign busy   = active || (en && !tx_empty);
  assign tx_svc = (tx_cnt <= CW'(txthr_q) + CW'(1));
  assign rx_svc = (rx_cnt >= CW'(rxthr_q) + CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      tof_q <= 1'b0;
    end else begin
      if (rx_push && rx_full)             ovr_q <= 1'b1;
      else if (stat_wr && wdata[ST_ROR])  ovr_q <= 1'b0;
      if (to_fire)                        tof_q <= 1'b1;
      else if (stat_wr && wdata[ST_RTO])  tof_q <= 1'b0;
    end
  end

  always_comb begin
    stat         = '0;
    stat[ST_TNF] = !tx_full;
    stat[ST_RNE] = !rx_empty;
    stat[ST_BSY] = busy;
    stat[ST_TSR] = tx_svc;
    stat[ST_RSR] = rx_svc;
    stat[ST_ROR] = ovr_q;
    stat[ST_RTO] = tof_q;
  end

  assign ctla_rd = {12'b0, div_q, en, 1'b0, fmt_q, size_m1_q};
  assign ctlb_rd = {12'b0, toie_q, 5'b0, rxthr_q, txthr_q, 1'b0,
                    cpha_q, cpol, loop_q, tie_q, rie_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= (rie_q && rx_svc) || (tie_q && tx_svc) || (toie_q && tof_q);
      if (rd_en) begin
        unique case (1'b1)
          sel_ctla: rdata <= ctla_rd;
          sel_ctlb: rdata <= ctlb_rd;
          sel_stat: rdata <= stat;
          sel_data: rdata <= BUS_W'(rx_dout);
          sel_tout: rdata <= BUS_W'(to_lim);
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              busy,
  input logic              sclk,
  input logic              cpol,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              ovr_q,
  input logic              tof_q
);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk == cpol));

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !(wr_en && addr == ADDR_W'(8) && wdata[7])) |=> ovr_q);

  // R10
  tout_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tof_q) |-> $past(rx_cnt != '0));

  // R11
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (rx_cnt == '0) && (tx_cnt == '0));
endmodule

bind ssp_port ssp_port_chk #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .busy(busy), .sclk(sclk), .cpol(cpol),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .ovr_q(ovr_q), .tof_q(tof_q)
);

// File: tb/tb_ssp_port.sv
module tb_ssp_port;
  localparam logic [7:0] CTLA = 8'h00, CTLB = 8'h04, STAT = 8'h08,
                         DATA = 8'h10, TOUT = 8'h28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, txd, rxd, irq;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign rxd = ~txd;

  ssp_port dut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
                .wdata(wdata), .rdata(rdata), .sclk(sclk), .txd(txd), .rxd(rxd),
                .irq(irq));

  // external receiver model: decodes sclk/txd as the mode defines
  logic        mon_arm = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
  logic [15:0] mon_word;
  int          mon_bits, mon_hi;
  logic        prev_sclk;
  always @(negedge clk) begin
    if (!mon_arm) begin
      mon_word <= '0; mon_bits <= 0; mon_hi <= 0; prev_sclk <= sclk;
    end else begin
      if (sclk != mon_cpol) mon_hi <= mon_hi + 1;
      if (sclk != prev_sclk && ((prev_sclk == mon_cpol) != mon_cpha)) begin
        mon_word <= {mon_word[14:0], txd};
        mon_bits <= mon_bits + 1;
      end
      prev_sclk <= sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(STAT, s);
      if (!s[4]) break;
    end
  endtask

  function automatic logic [15:0] fmask(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, s;
    logic [15:0] sent [17];
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(sclk == 0 && txd == 0 && irq == 0, "R1 pins", {sclk, txd, irq}, 0);
    rd(STAT, r);
    chk(r == 32'h24, "R1 status", r, 32'h24);

    // R2 readback masks
    wr(CTLA, 32'hFFFF_FFFF); rd(CTLA, r);
    chk(r == 32'h000F_FFBF, "R2 ctla", r, 32'h000F_FFBF);
    wr(CTLB, 32'hFFFF_FFFF); rd(CTLB, r);
    chk(r == 32'h0008_3FDF, "R2 ctlb", r, 32'h0008_3FDF);
    wr(TOUT, 32'hFFFF_FFFF); rd(TOUT, r);
    chk(r == 32'h0000_FFFF, "R2 tout", r, 32'h0000_FFFF);
    wr(CTLA, 0); wr(CTLB, 0); wr(TOUT, 0);

    // R3 R4 R5 R6 random frames in all modes
    for (int it = 0; it < 30; it++) begin
      int size, dv;
      bit cp, ch, lp;
      logic [15:0] w, exp_rx;
      size = 4 + int'($urandom % 13);
      dv   = int'($urandom % 4);
      cp = 1'($urandom); ch = 1'($urandom); lp = 1'($urandom);
      w  = 16'($urandom);
      wr(CTLB, (32'(ch) << 4) | (32'(cp) << 3) | (32'(lp) << 2));
      wr(CTLA, (32'(dv) << 8) | 32'h80 | 32'(size - 1));
      mon_cpol = cp; mon_cpha = ch;
      @(posedge clk); mon_arm = 1'b1;
      chk(sclk == cp, "R5 rest level", 32'(sclk), 32'(cp));
      wr(DATA, 32'(w));
      wait_idle();
      rd(DATA, r);
      exp_rx = lp ? (w & fmask(size)) : (~w & fmask(size));
      chk(r == 32'(exp_rx), lp ? "R3 loopback word" : "R4 rxd word", r, 32'(exp_rx));
      chk(mon_word == (w & fmask(size)) && mon_bits == size, "R6 line data",
          32'(mon_word), 32'(w & fmask(size)));
      chk(mon_hi == size * (dv + 1), "R5 half period", 32'(mon_hi), 32'(size * (dv + 1)));
      @(posedge clk); mon_arm = 1'b0;
    end

    // R9 overrun: 17 words with no reads
    wr(CTLB, 32'h4);
    wr(CTLA, 32'h87);
    for (int i = 0; i < 17; i++) begin
      sent[i] = 16'(i * 17 + 3) & 16'hFF;
      wr(DATA, 32'(sent[i]));
    end
    wait_idle();
    rd(STAT, s);
    chk(s[7] && s[3], "R9 overrun set", s, 32'h88);
    for (int i = 0; i < 16; i++) begin
      rd(DATA, r);
      chk(r == 32'(sent[i]), "R9 kept word", r, 32'(sent[i]));
    end
    rd(STAT, s);
    chk(s[7] && !s[3], "R9 sticky after drain", s, 32'h80);
    wr(STAT, 32'h80); rd(STAT, s);
    chk(!s[7], "R9 write-one clear", s, 0);

    // R8 receive threshold level 4 with interrupt
    wr(CTLB, 32'h4 | 32'h1 | (32'd3 << 10));
    for (int k = 1; k <= 4; k++) begin
      wr(DATA, 32'(k));
      wait_idle();
      rd(STAT, s);
      chk(s[6] == (k >= 4), "R8 rx request", 32'(s[6]), 32'(k >= 4));
      chk(irq == (k >= 4), "R8 rx irq", 32'(irq), 32'(k >= 4));
    end
    for (int k = 0; k < 4; k++) rd(DATA, r);

    // R10 idle time-out
    wr(CTLB, 32'h4 | (32'd1 << 19));
    wr(TOUT, 40);
    wr(DATA, 32'h5A);
    wait_idle();
    repeat (10) @(negedge clk);
    rd(STAT, s);
    chk(!s[19] && !irq, "R10 early", {s[19], irq}, 0);
    repeat (50) @(negedge clk);
    rd(STAT, s);
    chk(s[19] && irq, "R10 fired", {s[19], irq}, 3);
    wr(STAT, 32'h0008_0000); rd(STAT, s);
    chk(!s[19], "R10 clear", s, 0);
    rd(DATA, r);
    wr(TOUT, 0);
    wr(DATA, 32'h33);
    wait_idle();
    repeat (100) @(negedge clk);
    rd(STAT, s);
    chk(!s[19] && s[3], "R10 zero limit", s, 32'h8);
    rd(DATA, r);

    // R7 R12 R11 transmit threshold, busy, disable
    wr(CTLB, 32'h4 | 32'h2 | (32'd1 << 6));
    wr(CTLA, (32'd200 << 8) | 32'h80 | 32'd3);
    rd(STAT, s);
    chk(s[5] && irq, "R7 empty request", {s[5], irq}, 3);
    for (int i = 0; i < 4; i++) wr(DATA, 32'hA);
    rd(STAT, s);
    chk(!s[5] && !irq, "R7 above level", {s[5], irq}, 0);
    chk(s[4], "R12 busy while shifting", s, 32'h10);
    wr(CTLA, (32'd200 << 8) | 32'd3);
    rd(STAT, s);
    chk(!s[4] && !s[3] && s[2] && s[5], "R11 disable clears", s, 32'h24);
    wr(CTLA, (32'd200 << 8) | 32'h80 | 32'd3);
    repeat (4) @(negedge clk);
    rd(STAT, s);
    chk(!s[4] && sclk == 0, "R11 nothing resent", s, 32'h24);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule